// File: doc/BRIEF.md
# Pattern-Search Sequencer with Early Exit

This block is the control engine of a block-matching motion search. It runs a small program from an instruction memory. A check instruction takes a run of candidate offsets from a point memory, adds each one to the current search centre, and sends each resulting motion vector to an external SAD evaluator. Candidates go out one per cycle. Cost results come back in request order, each marked by a valid strobe. The engine keeps the lowest cost seen so far and the vector that produced it.

For each check instruction the engine also records which candidate, counted from 1, last lowered the cost. Conditional jumps test that record. A search loop can therefore stop as soon as a whole pattern fails to improve. The program does not depend on how many evaluators sit behind the request port, so the same binary runs on any evaluator count.

Motion vectors are in quarter-sample units. Integer patterns scale their offsets by four. Fractional patterns use their offsets as given.

Top module: `pss_seq`

## Requirements
- R1: After reset, and before any program has run, `busy`, `done`, `sad_req`, `best_pt` and `part_mode` are 0, `best_cost` is all ones and the best vector is (0,0). A `start` pulse while idle resets the program counter, the loop counter, the centre, the best vector, the best cost (all ones) and the partition mode. `busy` then stays high until a halt executes. `done` is high for exactly one cycle after the halt.
- R2: The instruction word is {opcode[19:16], A[15:8], B[7:0]}. Opcode 1 is the integer check: it issues A candidates, reading point-memory addresses B to B+A-1 in order. Each entry is {x[15:8], y[7:0]}, both signed. Each candidate is the centre plus four times the offset. Consecutive issues of one check step the point address by one.
- R3: Opcode 2 is the fractional check. It behaves like opcode 1 except that the offsets are added unscaled.
- R4: `best_pt` is cleared when a check instruction starts. When the check ends, `best_pt` holds the 1-based index of the last candidate in that check that lowered the best cost, or 0 if no candidate did.
- R5: The best cost and the best vector change during a check only when a returned cost is strictly lower than the stored best cost. A tie leaves the cost, the vector and `best_pt` unchanged.
- R6: When all the costs of a check have returned, the centre takes the best vector. The next pattern is built around that vector.
- R7: Opcode 3 jumps to A. Opcode 4 jumps to A when `best_pt` is nonzero. Opcode 5 jumps to A when `best_pt` is zero. When a conditional jump is not taken, the program counter advances by one.
- R8: Opcode 6 (loop) jumps to A while the iteration counter plus one is below B, and increments the counter. Otherwise it clears the counter and falls through. A loop body therefore runs B times in total.
- R9: Opcode 7 (seed) sets both the centre and the best vector to (A,B), read as signed values, and resets the best cost to all ones.
- R10: Opcode 8 sets `part_mode` to A[1:0`]`. The value holds until the next opcode 8 or the next start.
- R11: Opcode 0 and opcodes 9 to 15 halt the program.
- R12: A check with A = 0 issues no request, clears `best_pt`, and continues with the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts the program at address 0 when the engine is idle |
| busy | output | 1 | A program is running |
| done | output | 1 | One-cycle pulse after a halt |
| imem_addr | output | 8 | Instruction memory address (program counter) |
| imem_data | input | 20 | Instruction word, combinational read |
| pmem_addr | output | 8 | Point memory address |
| pmem_data | input | 16 | Offset pair {x, y}, combinational read |
| sad_req | output | 1 | A candidate vector is issued this cycle |
| sad_mv_x | output | 12 | Candidate x, quarter-sample units |
| sad_mv_y | output | 12 | Candidate y, quarter-sample units |
| sad_valid | input | 1 | A cost is returned this cycle, in request order |
| sad_cost | input | 16 | Returned cost |
| best_mv_x | output | 12 | Best vector x |
| best_mv_y | output | 12 | Best vector y |
| best_cost | output | 16 | Lowest cost so far |
| best_pt | output | 8 | 1-based index of the last improving point in the current check |
| part_mode | output | 2 | Partition mode set by the program |

## Verification
A wrong centre or a wrong offset scale shows up at once, on the very next `sad_req`, as a wrong vector. A wrong improvement decision changes `best_pt`. That in turn changes which conditional jump is taken, so the error then shows as a different request stream, a different request count or a different final `part_mode`, usually one loop iteration later. A candidate queue that lost order under a long evaluator latency would pair the wrong vector with a cost. That would show as a wrong best vector at the end of the program. The bench therefore replays each program in its own interpreter and compares every issued vector and every final result. It runs the programs at several return latencies, including one that fills the queue.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_HALT = 4'd0;
  localparam logic [OP_W-1:0] OP_CHKI = 4'd1;
  localparam logic [OP_W-1:0] OP_CHKF = 4'd2;
  localparam logic [OP_W-1:0] OP_JMP  = 4'd3;
  localparam logic [OP_W-1:0] OP_JMPI = 4'd4;
  localparam logic [OP_W-1:0] OP_JMPN = 4'd5;
  localparam logic [OP_W-1:0] OP_LOOP = 4'd6;
  localparam logic [OP_W-1:0] OP_SEED = 4'd7;
  localparam logic [OP_W-1:0] OP_MODE = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_CHK  = 2'd2
  } pss_state_e;

  function automatic logic is_check(input logic [OP_W-1:0] op);
    return (op == OP_CHKI) || (op == OP_CHKF);
  endfunction

  function automatic logic is_halt(input logic [OP_W-1:0] op);
    return (op == OP_HALT) || (op > OP_MODE);
  endfunction
endpackage

// File: rtl/pss_fifo.sv
module pss_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;

  assign full  = (fill == CNT_W'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> (!full || pop)); // R2
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R2
endmodule

// File: rtl/pss_best.sv
module pss_best #(
  parameter int MV_W   = 12,
  parameter int COST_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              seed_i,
  input  logic [MV_W-1:0]   seed_x,
  input  logic [MV_W-1:0]   seed_y,
  input  logic              pt_clr_i,
  input  logic              ret_i,
  input  logic [COST_W-1:0] ret_cost,
  input  logic [MV_W-1:0]   ret_x,
  input  logic [MV_W-1:0]   ret_y,
  input  logic [IDX_W-1:0]  ret_idx,
  output logic [MV_W-1:0]   best_x,
  output logic [MV_W-1:0]   best_y,
  output logic [COST_W-1:0] best_cost,
  output logic [IDX_W-1:0]  best_pt,
  output logic              improve_o
);
  // strict comparison: equal cost never wins
  function automatic logic beats(input logic [COST_W-1:0] cand, input logic [COST_W-1:0] cur);
    return cand < cur;
  endfunction

  assign improve_o = ret_i && beats(ret_cost, best_cost);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_x    <= '0;
      best_y    <= '0;
      best_cost <= '1;
      best_pt   <= '0;
    end else if (clr_i) begin
      best_x    <= '0;
      best_y    <= '0;
      best_cost <= '1;
      best_pt   <= '0;
    end else if (seed_i) begin
      best_x    <= seed_x;
      best_y    <= seed_y;
      best_cost <= '1;
    end else if (pt_clr_i) begin
      best_pt   <= '0;
    end else if (improve_o) begin
      best_x    <= ret_x;
      best_y    <= ret_y;
      best_cost <= ret_cost;
      best_pt   <= ret_idx;
    end
  end

  AST_TIE_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) (ret_i && !clr_i && !seed_i && ret_cost == best_cost) |=> (best_cost == $past(best_cost) && best_pt == $past(best_pt))); // R5
  AST_WIN_RECORDS_IDX: assert property (@(posedge clk) disable iff (!rst_n) (improve_o && !clr_i && !seed_i && !pt_clr_i) |=> (best_pt != '0)); // R4
endmodule

// File: rtl/pss_seq.sv
module pss_seq
  import pss_pkg::*;
#(
  parameter int FLD_W      = 8,
  parameter int OFF_W      = 8,
  parameter int MV_W       = 12,
  parameter int COST_W     = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     busy,
  output logic                     done,
  output logic [FLD_W-1:0]         imem_addr,
  input  logic [OP_W+2*FLD_W-1:0]  imem_data,
  output logic [FLD_W-1:0]         pmem_addr,
  input  logic [2*OFF_W-1:0]       pmem_data,
  output logic                     sad_req,
  output logic [MV_W-1:0]          sad_mv_x,
  output logic [MV_W-1:0]          sad_mv_y,
  input  logic                     sad_valid,
  input  logic [COST_W-1:0]        sad_cost,
  output logic [MV_W-1:0]          best_mv_x,
  output logic [MV_W-1:0]          best_mv_y,
  output logic [COST_W-1:0]        best_cost,
  output logic [FLD_W-1:0]         best_pt,
  output logic [1:0]               part_mode
);
  localparam int INSTR_W = OP_W + 2 * FLD_W;
  localparam int PAIR_W  = 2 * MV_W;

  // offset to quarter-sample vector delta; integer patterns scale by four
  function automatic logic [MV_W-1:0] widen_off(input logic [OFF_W-1:0] o, input logic fine);
    logic [MV_W-1:0] e;
    e = {{(MV_W-OFF_W){o[OFF_W-1]}}, o};
    return fine ? e : {e[MV_W-3:0], 2'b00};
  endfunction

  function automatic logic [MV_W-1:0] widen_fld(input logic [FLD_W-1:0] f);
    return {{(MV_W-FLD_W){f[FLD_W-1]}}, f};
  endfunction

  pss_state_e       state;
  logic [FLD_W-1:0] pc, loop_cnt, pt_cnt, pt_base, iss_cnt, ret_cnt;
  logic             frac_q;
  logic [MV_W-1:0]  ctr_x, ctr_y;
  logic [MV_W-1:0]  cand_x, cand_y, ret_x, ret_y;
  logic             q_full, q_empty, improve;
  logic             done_q;
  logic [1:0]       mode_q;

  logic [OP_W-1:0]  op;
  logic [FLD_W-1:0] opa, opb;
  assign op  = imem_data[INSTR_W-1 -: OP_W];
  assign opa = imem_data[2*FLD_W-1 -: FLD_W];
  assign opb = imem_data[FLD_W-1:0];

  // named internal events
  logic go_ev, exec_ev, chk_start, seed_ev, halt_ev, issue_ev, ret_ev, chk_end;
  assign go_ev     = (state == ST_IDLE) && start;
  assign exec_ev   = (state == ST_EXEC);
  assign chk_start = exec_ev && is_check(op);
  assign seed_ev   = exec_ev && (op == OP_SEED);
  assign halt_ev   = exec_ev && is_halt(op);
  assign issue_ev  = (state == ST_CHK) && (iss_cnt < pt_cnt) && !q_full;
  assign ret_ev    = (state == ST_CHK) && sad_valid;
  assign chk_end   = (state == ST_CHK) && (ret_cnt == pt_cnt);

  assign cand_x = ctr_x + widen_off(pmem_data[2*OFF_W-1 -: OFF_W], frac_q);
  assign cand_y = ctr_y + widen_off(pmem_data[OFF_W-1:0], frac_q);

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign imem_addr = pc;
  assign pmem_addr = pt_base + iss_cnt;
  assign sad_req   = issue_ev;
  assign sad_mv_x  = cand_x;
  assign sad_mv_y  = cand_y;
  assign part_mode = mode_q;

  pss_fifo #(.W(PAIR_W), .DEPTH(FIFO_DEPTH)) u_inflight (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (issue_ev),
    .din   ({cand_x, cand_y}),
    .pop   (ret_ev),
    .dout  ({ret_x, ret_y}),
    .full  (q_full),
    .empty (q_empty)
  );

  pss_best #(.MV_W(MV_W), .COST_W(COST_W), .IDX_W(FLD_W)) u_best (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (go_ev),
    .seed_i    (seed_ev),
    .seed_x    (widen_fld(opa)),
    .seed_y    (widen_fld(opb)),
    .pt_clr_i  (chk_start),
    .ret_i     (ret_ev),
    .ret_cost  (sad_cost),
    .ret_x     (ret_x),
    .ret_y     (ret_y),
    .ret_idx   (ret_cnt + 1'b1),
    .best_x    (best_mv_x),
    .best_y    (best_mv_y),
    .best_cost (best_cost),
    .best_pt   (best_pt),
    .improve_o (improve)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      pc       <= '0;
      loop_cnt <= '0;
      pt_cnt   <= '0;
      pt_base  <= '0;
      iss_cnt  <= '0;
      ret_cnt  <= '0;
      frac_q   <= 1'b0;
      ctr_x    <= '0;
      ctr_y    <= '0;
      mode_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_EXEC;
            pc       <= '0;
            loop_cnt <= '0;
            ctr_x    <= '0;
            ctr_y    <= '0;
            mode_q   <= '0;
          end
        end
        ST_EXEC: begin
          case (op)
            OP_CHKI, OP_CHKF: begin
              pt_cnt  <= opa;
              pt_base <= opb;
              frac_q  <= (op == OP_CHKF);
              iss_cnt <= '0;
              ret_cnt <= '0;
              state   <= ST_CHK;
            end
            OP_JMP:  pc <= opa;
            OP_JMPI: pc <= (best_pt != '0) ? opa : pc + 1'b1;
            OP_JMPN: pc <= (best_pt == '0) ? opa : pc + 1'b1;
            OP_LOOP: begin
              if ((loop_cnt + 1'b1) < opb) begin
                loop_cnt <= loop_cnt + 1'b1;
                pc       <= opa;
              end else begin
                loop_cnt <= '0;
                pc       <= pc + 1'b1;
              end
            end
            OP_SEED: begin
              ctr_x <= widen_fld(opa);
              ctr_y <= widen_fld(opb);
              pc    <= pc + 1'b1;
            end
            OP_MODE: begin
              mode_q <= opa[1:0];
              pc     <= pc + 1'b1;
            end
            default: begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
        ST_CHK: begin
          if (issue_ev) iss_cnt <= iss_cnt + 1'b1;
          if (ret_ev)   ret_cnt <= ret_cnt + 1'b1;
          if (chk_end) begin
            ctr_x <= best_mv_x;
            ctr_y <= best_mv_y;
            pc    <= pc + 1'b1;
            state <= ST_EXEC;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_PT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) chk_start |=> (best_pt == '0)); // R4
  AST_COST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n) (busy && !seed_ev) |=> (best_cost <= $past(best_cost))); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n) sad_req |=> (!sad_req || pmem_addr == $past(pmem_addr) + 1'b1)); // R2
  AST_CENTRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) chk_end |=> (ctr_x == best_mv_x && ctr_y == best_mv_y)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R1
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) halt_ev |=> (!busy && done)); // R11
  AST_NO_RET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) improve |-> busy); // R5
endmodule

// File: tb/tb_pss_seq.sv
`timescale 1ns/1ps
module tb_pss_seq;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, busy, done, sad_req, sad_valid;
  logic [7:0]  imem_addr, pmem_addr, best_pt;
  logic [19:0] imem_data;
  logic [15:0] pmem_data, sad_cost, best_cost;
  logic [11:0] sad_mv_x, sad_mv_y, best_mv_x, best_mv_y;
  logic [1:0]  part_mode;

  logic [19:0] imem [0:255];
  logic [15:0] pmem [0:255];
  assign imem_data = imem[imem_addr];
  assign pmem_data = pmem[pmem_addr];

  pss_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .pmem_addr(pmem_addr), .pmem_data(pmem_data),
    .sad_req(sad_req), .sad_mv_x(sad_mv_x), .sad_mv_y(sad_mv_y),
    .sad_valid(sad_valid), .sad_cost(sad_cost),
    .best_mv_x(best_mv_x), .best_mv_y(best_mv_y), .best_cost(best_cost),
    .best_pt(best_pt), .part_mode(part_mode)
  );

  int checks = 0, errors = 0;
  int lat = 1, tx = 0, ty = 0, fc = 0;
  bit flat = 0;
  int exp_x [0:2047];
  int exp_y [0:2047];
  int n_exp = 0, n_obs = 0, first_x = 0, first_y = 0;
  int m_bx, m_by, m_cost, m_pt, m_mode;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int sx12(input logic [11:0] v);
    return int'($signed(v));
  endfunction

  function automatic int wrap12(input int v);
    logic [11:0] t;
    t = v[11:0];
    return int'($signed(t));
  endfunction

  function automatic int s8(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  function automatic int costf(input int x, input int y);
    int dx, dy;
    if (flat) return fc;
    dx = (x > tx) ? x - tx : tx - x;
    dy = (y > ty) ? y - ty : ty - y;
    return (dx + dy) & 65535;
  endfunction

  function automatic logic [19:0] ins(input int op, input int a, input int b);
    return {4'(op), 8'(a), 8'(b)};
  endfunction

  function automatic logic [15:0] pt(input int x, input int y);
    return {8'(x), 8'(y)};
  endfunction

  // independent interpreter of the program, built from the requirements
  task automatic model_run();
    int pcm, lc, cx, cy, c, x, y, ox, oy;
    logic [19:0] w;
    int op, a, b;
    pcm = 0; lc = 0; cx = 0; cy = 0;
    m_bx = 0; m_by = 0; m_cost = 65535; m_pt = 0; m_mode = 0; n_exp = 0;
    for (int step = 0; step < 4000; step++) begin
      w = imem[pcm[7:0]];
      op = int'(w[19:16]); a = int'(w[15:8]); b = int'(w[7:0]);
      if (op == 1 || op == 2) begin
        m_pt = 0;
        for (int k = 0; k < a; k++) begin
          ox = s8(pmem[(b + k) & 255][15:8]);
          oy = s8(pmem[(b + k) & 255][7:0]);
          if (op == 1) begin ox = ox * 4; oy = oy * 4; end
          x = wrap12(cx + ox); y = wrap12(cy + oy);
          if (n_exp < 2048) begin exp_x[n_exp] = x; exp_y[n_exp] = y; end
          n_exp++;
          c = costf(x, y);
          if (c < m_cost) begin m_cost = c; m_bx = x; m_by = y; m_pt = k + 1; end
        end
        cx = m_bx; cy = m_by; pcm = pcm + 1;
      end else if (op == 3) pcm = a;
      else if (op == 4) pcm = (m_pt != 0) ? a : pcm + 1;
      else if (op == 5) pcm = (m_pt == 0) ? a : pcm + 1;
      else if (op == 6) begin
        if (lc + 1 < b) begin lc = lc + 1; pcm = a; end
        else begin lc = 0; pcm = pcm + 1; end
      end else if (op == 7) begin
        cx = s8(8'(a)); cy = s8(8'(b)); m_bx = cx; m_by = cy; m_cost = 65535; pcm = pcm + 1;
      end else if (op == 8) begin
        m_mode = a & 3; pcm = pcm + 1;
      end else break;
      pcm = pcm & 255;
    end
  endtask

  // SAD evaluator model and request monitor, acting at the falling edge
  int  pv [0:4];
  int  pcs [0:4];
  initial begin
    sad_valid = 1'b0;
    sad_cost  = '0;
    for (int i = 0; i < 5; i++) begin pv[i] = 0; pcs[i] = 0; end
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        for (int i = 0; i < 5; i++) pv[i] = 0;
        sad_valid = 1'b0;
      end else begin
        for (int i = 4; i > 0; i--) begin pv[i] = pv[i-1]; pcs[i] = pcs[i-1]; end
        pv[0]  = int'(sad_req);
        pcs[0] = costf(sx12(sad_mv_x), sx12(sad_mv_y));
        if (sad_req) begin
          if (n_obs == 0) begin first_x = sx12(sad_mv_x); first_y = sx12(sad_mv_y); end
          if (n_obs < n_exp && n_obs < 2048) begin
            check(sx12(sad_mv_x) == exp_x[n_obs], "R2/R3 request x", sx12(sad_mv_x), exp_x[n_obs]);
            check(sx12(sad_mv_y) == exp_y[n_obs], "R2/R3 request y", sx12(sad_mv_y), exp_y[n_obs]);
          end else begin
            check(1'b0, "R2 extra request", n_obs + 1, n_exp);
          end
          n_obs++;
        end
        sad_valid = pv[lat][0];
        sad_cost  = 16'(pcs[lat]);
      end
    end
  end

  task automatic run_prog(input int l);
    int cyc;
    lat = l;
    model_run();
    n_obs = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    check(done == 1'b1, "R1 done reached (watchdog)", int'(done), 1);
    @(negedge clk);
    check(!done && !busy, "R1 done single cycle and idle", int'(done) + 2 * int'(busy), 0);
    check(n_obs == n_exp, "R2 request count", n_obs, n_exp);
    check(sx12(best_mv_x) == m_bx, "R6 best x", sx12(best_mv_x), m_bx);
    check(sx12(best_mv_y) == m_by, "R6 best y", sx12(best_mv_y), m_by);
    check(int'(best_cost) == m_cost, "R5 best cost", int'(best_cost), m_cost);
    check(int'(best_pt) == m_pt, "R4 best point", int'(best_pt), m_pt);
    check(int'(part_mode) == m_mode, "R10 partition mode", int'(part_mode), m_mode);
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 256; i++) imem[i] = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 global watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    for (int i = 0; i < 256; i++) pmem[i] = '0;
    clear_imem();
    pmem[0] = pt(0, 1);  pmem[1] = pt(1, 0);  pmem[2] = pt(0, -1); pmem[3] = pt(-1, 0);
    pmem[16] = pt(-1, -1); pmem[17] = pt(0, -1); pmem[18] = pt(1, -1); pmem[19] = pt(-1, 0);
    pmem[20] = pt(1, 0);   pmem[21] = pt(-1, 1);  pmem[22] = pt(0, 1);  pmem[23] = pt(1, 1);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !sad_req, "R1 reset outputs low", int'(busy) + int'(done) + int'(sad_req), 0);
    check(best_cost == 16'hFFFF, "R1 reset best cost", int'(best_cost), 65535);
    check(best_pt == 8'd0 && part_mode == 2'd0, "R1 reset point and mode", int'(best_pt) + int'(part_mode), 0);

    // diamond descent with early exit, then fractional refinement (R2, R3, R6, R7)
    clear_imem();
    imem[0] = ins(8, 2, 0); imem[1] = ins(1, 4, 0); imem[2] = ins(4, 1, 0);
    imem[3] = ins(2, 8, 16); imem[4] = ins(0, 0, 0);
    flat = 0;
    for (int t = 0; t < 6; t++) begin
      tx = -30 + t * 13;
      ty = 25 - t * 11;
      run_prog(1 + (t % 4));
    end

    // loop, seed, jumps and illegal opcode with a flat cost surface
    clear_imem();
    imem[0] = ins(7, 5, 8'hFD); imem[1] = ins(1, 4, 0); imem[2] = ins(6, 1, 3);
    imem[3] = ins(5, 6, 0); imem[4] = ins(8, 1, 0); imem[5] = ins(0, 0, 0);
    imem[6] = ins(8, 3, 0); imem[7] = ins(3, 9, 0); imem[8] = ins(8, 0, 0);
    imem[9] = ins(12, 0, 0);
    flat = 1; fc = 100;
    run_prog(2);
    check(n_obs == 12, "R8 loop body three times", n_obs, 12);
    check(first_x == 5 && first_y == 1, "R9 seed centre x", first_x * 100 + first_y, 501);
    check(part_mode == 2'd3, "R7 jump path mode", int'(part_mode), 3);
    check(!busy, "R11 illegal opcode halts", int'(busy), 0);

    // tie between first two points
    clear_imem();
    imem[0] = ins(1, 4, 0); imem[1] = ins(0, 0, 0);
    flat = 0; tx = 2; ty = 2;
    run_prog(3);
    check(best_pt == 8'd1, "R5 tie keeps first point", int'(best_pt), 1);
    check(best_cost == 16'd4, "R5 tie cost", int'(best_cost), 4);
    check(sx12(best_mv_x) == 0 && sx12(best_mv_y) == 4, "R5 tie vector", sx12(best_mv_y), 4);

    // zero-length check clears the point record
    clear_imem();
    imem[0] = ins(7, 0, 0); imem[1] = ins(1, 4, 0); imem[2] = ins(1, 0, 0);
    imem[3] = ins(5, 6, 0); imem[4] = ins(8, 1, 0); imem[5] = ins(0, 0, 0);
    imem[6] = ins(8, 2, 0); imem[7] = ins(0, 0, 0);
    tx = 40; ty = 0;
    run_prog(1);
    check(n_obs == 4, "R12 empty check issues nothing", n_obs, 4);
    check(best_pt == 8'd0, "R12 empty check clears point", int'(best_pt), 0);
    check(part_mode == 2'd2, "R12 jump after empty check", int'(part_mode), 2);
    check(sx12(best_mv_x) == 4 && best_cost == 16'd36, "R4 second point won", sx12(best_mv_x), 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule